// File: doc/BRIEF.md
# Per-Component Condition Code Predication Unit

This unit works beside a four-lane vector datapath and stands in for data-dependent branching. A compare operation takes two source vectors and writes, for each lane, a three-flag status (less, equal, greater) into one of several condition code banks. A later operation that writes the register file names a bank and a test, such as greater-than. Its destination lanes are written only where the chosen status passes that test.

The status is read through a per-lane swizzle. Each destination lane can therefore be gated by any source lane's status. For example, a broadcast of lane x lets one comparison control all four lanes. The unit has no jump or loop logic. It gives the register file a registered per-lane write enable one cycle after the operation is presented.

A compare and a predicated write may be issued together. The predicated write always uses the status held before that cycle's compare. The new status applies from the next operation. Operands are compared as signed two's-complement integers.

Top module: `pcc_predicate_unit`

## Requirements
- R1: When `set_cc` is high, each lane i compares `src_a` lane i with `src_b` lane i (lane i at bits [32*i+31:32*i]). It stores exactly one of the flags less (bit 0), equal (bit 1) or greater (bit 2) for that lane in bank `set_sel`.
- R2: A compare writes only the bank selected by `set_sel`. Every other bank keeps its contents.
- R3: `test_code` selects the set of flags that pass: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. A lane passes when its selected status holds any flag in that set.
- R4: Destination lane i reads the status of source lane `cc_swz[2*i+1:2*i]` (0=x, 1=y, 2=z, 3=w) from bank `rd_sel`.
- R5: `wr_en[i]` is high one cycle after an operation exactly when `wr_valid`, `wr_mask[i]` and the swizzled test result for lane i are all high. It is low after any cycle with `wr_valid` low.
- R6: A predicated write issued in the same cycle as a compare uses the status held before that compare. The new status governs operations from the next cycle on.
- R7: Synchronous reset sets every lane of every bank to the equal status and drives `wr_en` to zero.
- R8: While `set_cc` is low, no bank changes, whatever the source operands are.
- R9: Comparison is signed: 32'h80000000 is less than 32'h7FFFFFFF, and -1 is less than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_cc | input | 1 | Compare valid; update a condition bank |
| set_sel | input | 1 | Bank receiving the compare result |
| src_a | input | 128 | First compare operand, four signed 32-bit lanes |
| src_b | input | 128 | Second compare operand, four signed 32-bit lanes |
| wr_valid | input | 1 | A register-file write is being issued |
| rd_sel | input | 1 | Bank read for the predicate test |
| test_code | input | 3 | Condition test |
| cc_swz | input | 8 | Per-lane condition swizzle, 2 bits per destination lane |
| wr_mask | input | 4 | Destination write mask |
| wr_en | output | 4 | Registered per-lane write enables |

## Verification
On every cycle, the bound checker confirms the following. No enable rises outside the previous cycle's mask or without a valid write. The never and always tests give zero and the mask. Each stored lane status holds exactly one flag. Banks stay unchanged when no compare is issued, and leaving reset gives zero enables.

Only the bench's scenarios can show the value-level behaviour. This covers the signed ordering of operands and which bank a compare lands in. It also covers the swizzle routing and the one-operation delay between a compare and its effect, which the bench checks against its own model of the banks.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int FLAG_W = 3;
  // flag bit positions inside a lane status
  localparam int F_LT = 0;
  localparam int F_EQ = 1;
  localparam int F_GT = 2;
  localparam logic [FLAG_W-1:0] STATUS_EQ = 3'b010;

  // test codes are the set of passing flags, so decode is a simple AND
  typedef enum logic [2:0] {
    TST_FL = 3'd0,
    TST_LT = 3'd1,
    TST_EQ = 3'd2,
    TST_LE = 3'd3,
    TST_GT = 3'd4,
    TST_NE = 3'd5,
    TST_GE = 3'd6,
    TST_TR = 3'd7
  } test_e;
endpackage

// File: rtl/pcc_cmp_lane.sv
module pcc_cmp_lane
  import pcc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  output logic [FLAG_W-1:0] status
);
  logic is_lt;
  logic is_eq;

  always_comb begin
    is_lt = $signed(op_a) < $signed(op_b);
    is_eq = (op_a == op_b);
    status        = '0;
    status[F_LT]  = is_lt;
    status[F_EQ]  = is_eq;
    status[F_GT]  = !is_lt && !is_eq;
  end
endmodule

// File: rtl/pcc_cc_bank.sv
module pcc_cc_bank
  import pcc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NUM_CC = 2,
  parameter int SEL_W  = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              set_cc,
  input  logic [SEL_W-1:0]                  set_sel,
  input  logic [LANES*FLAG_W-1:0]           new_status,
  output logic [NUM_CC*LANES*FLAG_W-1:0]    cc_flat
);
  localparam int ROW_W = LANES * FLAG_W;

  for (genvar r = 0; r < NUM_CC; r++) begin : g_bank
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= {LANES{STATUS_EQ}};
      end else if (set_cc && (set_sel == SEL_W'(r))) begin
        row_q <= new_status;
      end
    end
    assign cc_flat[r*ROW_W +: ROW_W] = row_q;
  end
endmodule

// File: rtl/pcc_test_lane.sv
module pcc_test_lane
  import pcc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SWZ_W = 2
) (
  input  logic [LANES*FLAG_W-1:0] cc_row,
  input  logic [SWZ_W-1:0]        swz,
  input  logic [2:0]              test,
  output logic                    pass
);
  logic [FLAG_W-1:0] picked;

  always_comb begin
    picked = cc_row[int'(swz)*FLAG_W +: FLAG_W];
    pass   = |(test & picked);
  end
endmodule

// File: rtl/pcc_predicate_unit.sv
module pcc_predicate_unit
  import pcc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DW     = 32,
  parameter int NUM_CC = 2,
  localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1,
  localparam int SWZ_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_cc,
  input  logic [SEL_W-1:0]       set_sel,
  input  logic [LANES*DW-1:0]    src_a,
  input  logic [LANES*DW-1:0]    src_b,
  input  logic                   wr_valid,
  input  logic [SEL_W-1:0]       rd_sel,
  input  logic [2:0]             test_code,
  input  logic [LANES*SWZ_W-1:0] cc_swz,
  input  logic [LANES-1:0]       wr_mask,
  output logic [LANES-1:0]       wr_en
);
  localparam int ROW_W = LANES * FLAG_W;

  logic [ROW_W-1:0]               new_status;
  logic [NUM_CC*ROW_W-1:0]        cc_flat;
  logic [ROW_W-1:0]               cc_row;
  logic [LANES-1:0]               lane_pass;
  logic [LANES-1:0]               wr_en_q;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    pcc_cmp_lane #(.DW(DW)) u_cmp (
      .op_a   (src_a[i*DW +: DW]),
      .op_b   (src_b[i*DW +: DW]),
      .status (new_status[i*FLAG_W +: FLAG_W])
    );
  end

  pcc_cc_bank #(.LANES(LANES), .NUM_CC(NUM_CC), .SEL_W(SEL_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_cc     (set_cc),
    .set_sel    (set_sel),
    .new_status (new_status),
    .cc_flat    (cc_flat)
  );

  // read side sees the bank contents from before this cycle's compare
  always_comb begin
    cc_row = cc_flat[int'(rd_sel)*ROW_W +: ROW_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_test
    pcc_test_lane #(.LANES(LANES), .SWZ_W(SWZ_W)) u_test (
      .cc_row (cc_row),
      .swz    (cc_swz[i*SWZ_W +: SWZ_W]),
      .test   (test_code),
      .pass   (lane_pass[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q <= '0;
    end else if (wr_valid) begin
      wr_en_q <= wr_mask & lane_pass;
    end else begin
      wr_en_q <= '0;
    end
  end

  assign wr_en = wr_en_q;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NUM_CC = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           set_cc,
  input logic                           wr_valid,
  input logic [2:0]                     test_code,
  input logic [LANES-1:0]               wr_mask,
  input logic [LANES-1:0]               wr_en,
  input logic [NUM_CC*LANES*FLAG_W-1:0] cc_flat
);
  p_in_mask_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wr_en & ~$past(wr_mask)) == '0));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> (wr_en == '0));

  p_never_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && test_code == TST_FL) |=> (wr_en == '0));

  p_always_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && test_code == TST_TR) |=> (wr_en == $past(wr_mask)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> $stable(cc_flat));

  p_exit_rst_r7: assert property (@(posedge clk)
    $fell(rst) |-> (wr_en == '0));

  for (genvar k = 0; k < NUM_CC * LANES; k++) begin : g_one
    p_one_flag_r1: assert property (@(posedge clk) disable iff (rst)
      $countones(cc_flat[k*FLAG_W +: FLAG_W]) == 1);
  end
endmodule

bind pcc_predicate_unit pcc_checker #(.LANES(LANES), .NUM_CC(NUM_CC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_cc    (set_cc),
  .wr_valid  (wr_valid),
  .test_code (test_code),
  .wr_mask   (wr_mask),
  .wr_en     (wr_en),
  .cc_flat   (cc_flat)
);

// File: tb/tb_pcc_predicate_unit.sv
module tb_pcc_predicate_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         set_cc = 1'b0;
  logic [0:0]   set_sel = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         wr_valid = 1'b0;
  logic [0:0]   rd_sel = '0;
  logic [2:0]   test_code = '0;
  logic [7:0]   cc_swz = '0;
  logic [3:0]   wr_mask = '0;
  logic [3:0]   wr_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  logic [2:0] m_cc [2][4];

  localparam logic [7:0] SWZ_ID  = 8'b11_10_01_00;
  localparam logic [7:0] SWZ_REV = 8'b00_01_10_11;

  always #4 clk = ~clk;

  pcc_predicate_unit dut (
    .clk(clk), .rst(rst), .set_cc(set_cc), .set_sel(set_sel),
    .src_a(src_a), .src_b(src_b), .wr_valid(wr_valid), .rd_sel(rd_sel),
    .test_code(test_code), .cc_swz(cc_swz), .wr_mask(wr_mask), .wr_en(wr_en)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wr_en actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_cmp(input logic [31:0] a, input logic [31:0] b);
    if ($signed(a) < $signed(b)) return 3'b001;
    if (a == b) return 3'b010;
    return 3'b100;
  endfunction

  // driver: present one operation at a falling edge and push its expected result
  task automatic issue(input logic sc, input logic ss, input logic [127:0] a,
                       input logic [127:0] b, input logic v, input logic rs,
                       input logic [2:0] tc, input logic [7:0] swz,
                       input logic [3:0] mask, input string tag);
    item_t it;
    @(negedge clk);
    set_cc = sc; set_sel = ss; src_a = a; src_b = b;
    wr_valid = v; rd_sel = rs; test_code = tc; cc_swz = swz; wr_mask = mask;
    for (int i = 0; i < 4; i++) begin
      logic [2:0] f;
      f = m_cc[rs][swz[2*i +: 2]];
      it.exp[i] = v & mask[i] & (|(tc & f));
    end
    it.tag = tag;
    sb.push_back(it);
    if (sc) for (int i = 0; i < 4; i++) m_cc[ss][i] = ref_cmp(a[32*i +: 32], b[32*i +: 32]);
  endtask

  task automatic idle();
    issue(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 3'd0, SWZ_ID, 4'h0, "R5 idle");
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(wr_en, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a0, b0;
    for (int r = 0; r < 2; r++) for (int i = 0; i < 4; i++) m_cc[r][i] = 3'b010;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check(wr_en, 4'h0, "R7 reset output");

    // R7: all banks start equal
    issue(0, 0, '0, '0, 1, 0, 3'd2, SWZ_ID, 4'hF, "R7 bank0 equal after reset");
    issue(0, 0, '0, '0, 1, 1, 3'd2, SWZ_ID, 4'hF, "R7 bank1 equal after reset");

    // R1/R6/R9: x gt, y lt (-3<4), z eq, w gt (0>-1); same-cycle uses old status
    a0 = {32'd0, 32'd7, -32'sd3, 32'd5};
    b0 = {-32'sd1, 32'd7, 32'd4, 32'd2};
    issue(1, 0, a0, b0, 1, 0, 3'd4, SWZ_ID, 4'hF, "R6 same-cycle uses old status");
    issue(0, 0, '0, '0, 1, 0, 3'd4, SWZ_ID, 4'hF, "R1 GT");
    issue(0, 0, '0, '0, 1, 0, 3'd1, SWZ_ID, 4'hF, "R9 LT signed");
    issue(0, 0, '0, '0, 1, 0, 3'd2, SWZ_ID, 4'hF, "R3 EQ");
    issue(0, 0, '0, '0, 1, 0, 3'd3, SWZ_ID, 4'hF, "R3 LE");
    issue(0, 0, '0, '0, 1, 0, 3'd6, SWZ_ID, 4'hF, "R3 GE");
    issue(0, 0, '0, '0, 1, 0, 3'd5, SWZ_ID, 4'hF, "R3 NE");
    issue(0, 0, '0, '0, 1, 0, 3'd0, SWZ_ID, 4'hF, "R3 FL");
    issue(0, 0, '0, '0, 1, 0, 3'd7, SWZ_ID, 4'hF, "R3 TR");
    issue(0, 0, '0, '0, 1, 1, 3'd2, SWZ_ID, 4'hF, "R2 bank1 untouched");

    // R4 swizzle
    issue(0, 0, '0, '0, 1, 0, 3'd4, 8'h00, 4'hF, "R4 broadcast x");
    issue(0, 0, '0, '0, 1, 0, 3'd1, 8'h55, 4'hF, "R4 broadcast y");
    issue(0, 0, '0, '0, 1, 0, 3'd2, SWZ_REV, 4'hF, "R4 reversed");

    // R5 mask and valid
    issue(0, 0, '0, '0, 1, 0, 3'd4, SWZ_ID, 4'h1, "R5 mask");
    issue(0, 0, '0, '0, 0, 0, 3'd7, SWZ_ID, 4'hF, "R5 not valid");

    // R8: operands change without set_cc
    issue(0, 0, {4{32'd9}}, {4{32'd1}}, 1, 0, 3'd4, SWZ_ID, 4'hF, "R8 pre");
    issue(0, 0, '0, '0, 1, 0, 3'd4, SWZ_ID, 4'hF, "R8 bank0 held");

    // R2/R9: compare into bank1 with signed extremes, all less
    issue(1, 1, {32'h80000000, -32'sd1, -32'sd5, 32'h80000000},
                {32'h7FFFFFFF, 32'd0, 32'd5, 32'd0}, 0, 0, 3'd0, SWZ_ID, 4'h0, "R2 load bank1");
    issue(0, 0, '0, '0, 1, 1, 3'd1, SWZ_ID, 4'hF, "R9 bank1 all less");
    issue(0, 0, '0, '0, 1, 0, 3'd4, SWZ_ID, 4'hF, "R2 bank0 still");

    // back-to-back compare then use
    issue(1, 0, {4{32'd3}}, {4{32'd3}}, 1, 0, 3'd2, SWZ_ID, 4'hF, "R6 old status");
    issue(0, 0, '0, '0, 1, 0, 3'd2, SWZ_ID, 4'hF, "R6 new status");

    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [127:0] ra, rb;
      for (int i = 0; i < 4; i++) begin
        ra[32*i +: 32] = ($urandom_range(0, 3) == 0) ? 32'd4 : $urandom;
        rb[32*i +: 32] = ($urandom_range(0, 3) == 0) ? 32'd4 : $urandom;
      end
      issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra, rb,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
            8'($urandom), 4'($urandom), "R1 R3 R4 R5 random");
    end
    idle();
    idle();
    @(posedge clk); #3;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule